// File: doc/BRIEF.md
# Tree Select Arbiter

This block chooses which ready entries of an instruction issue window go to the functional units in the next cycle. Every window entry raises a request bit. The block returns one grant vector for each functional unit. Each grant vector marks at most one entry.

Selection is made by a tree of four-input arbiter cells. Each cell sends a summary bit, meaning "some child is requesting", up to its parent. An enable comes down from the root of the tree. A cell passes that enable to its lowest-indexed requesting child, and only when the cell itself is enabled. At the leaves the enable becomes the grant. Each cell uses fixed priority, so the window should keep older entries at lower indices.

To serve more than one unit, one tree per unit is placed in series. Each later tree sees the original requests with every earlier grant removed. The root enable of each tree is tied to "this unit is free". The grants and the valid flags are registered, so they appear one clock after the requests are sampled.

Top module: `sel_multi`

## Requirements
- R1: While `rst_n` is low at a rising edge, all grant bits and all valid flags become 0 at that edge.
- R2: Outputs reflect the inputs sampled at the previous rising edge. With `unit_free[0]`=1, `grant[0]` holds a single 1 at the lowest-indexed entry `i` whose `req[i]`=1. Bit `i` of a grant vector corresponds to entry `i`.
- R3: Stage `s`>0 grants the lowest-indexed entry that is requesting and was not granted by any lower-numbered stage in the same cycle. If stage 0 is not free, stage 1 therefore receives the lowest requesting entry.
- R4: When `unit_free[s]`=0, `grant[s]` is all zero and `grant_vld[s]`=0, whatever the requests are.
- R5: When no entry requests, or when every request has been taken by earlier stages, the grant vector of that stage is zero and its valid flag is 0.
- R6: Each grant vector has at most one bit set. `grant_vld[s]` is 1 exactly when `grant[s]` is nonzero.
- R7: No entry is granted by two stages in the same cycle.
- R8: A grant bit is set only for an entry whose request bit was set in the sampled cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | N (64) | Request bit per window entry |
| unit_free | input | STAGES (2) | Root enable per stage, set when that unit is free |
| grant | output | STAGES x N | One-hot-or-zero grant vector per stage, entry 0 in bit 0 |
| grant_vld | output | STAGES (2) | Set when the matching grant vector is nonzero |

## Verification
The directed patterns are chosen to separate specific faults:
- An empty window and a full window.
- A lone request at the top index, which exposes a broken path through the deepest cell.
- A lone request with both units free, which shows that the second stage stays empty once the first stage has taken the only request.
- Requests in two different subtrees, which checks that priority holds across cell boundaries as well as inside one cell.

Random requests of sparse, medium and dense density, together with all four unit-free combinations, check the cascade masking. They also check that a busy first unit hands the oldest entry to the second unit.

// File: rtl/sel_pkg.sv
// Shared constants for the tree select arbiter.
package sel_pkg;
    // Number of children under each arbiter cell.
    localparam int unsigned CELL_RADIX = 4;
endpackage

// File: rtl/sel_cell.sv
// One arbiter cell of the select tree.
// Reports whether any child requests, and forwards its enable to the
// lowest-indexed requesting child. Assumes the children are ordered by age.
module sel_cell #(
    parameter int unsigned RADIX = sel_pkg::CELL_RADIX
) (
    input  logic [RADIX-1:0] req_i,
    input  logic             en_i,
    output logic             any_o,
    output logic [RADIX-1:0] gnt_o
);
    // Summary of the requests, sent up to the parent cell.
    assign any_o = |req_i;

    // Fixed priority: the lowest index wins, and only while enabled.
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt_o = '0;
        for (int k = 0; k < RADIX; k++) begin
            if (req_i[k] && !taken) begin
                gnt_o[k] = en_i;
                taken    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sel_tree.sv
// Select tree for one functional unit.
// Requests are summarised upward level by level, and the root enable is
// steered downward to a single leaf. Assumes N is a power of RADIX.
module sel_tree #(
    parameter int unsigned N     = 64,
    parameter int unsigned RADIX = sel_pkg::CELL_RADIX
) (
    input  logic [N-1:0] req_i,
    input  logic         root_en_i,
    output logic [N-1:0] gnt_o,
    output logic         any_o
);
    localparam int unsigned LEVELS = $clog2(N) / $clog2(RADIX);

    // Level 0 holds the leaves. Level LEVELS holds the root output.
    logic [N-1:0] up_v [LEVELS+1];
    logic [N-1:0] dn_v [LEVELS+1];

    assign up_v[0] = req_i;
    assign gnt_o   = dn_v[0];
    assign any_o   = up_v[LEVELS][0];
    assign dn_v[LEVELS][0] = root_en_i;

    genvar l, c;
    generate
        for (l = 0; l < LEVELS; l++) begin : g_lvl
            localparam int unsigned CELLS = N / (RADIX ** (l + 1));
            localparam int unsigned USED  = N / (RADIX ** l);
            for (c = 0; c < CELLS; c++) begin : g_cell
                sel_cell #(.RADIX(RADIX)) u_cell (
                    .req_i (up_v[l][c*RADIX +: RADIX]),
                    .en_i  (dn_v[l+1][c]),
                    .any_o (up_v[l+1][c]),
                    .gnt_o (dn_v[l][c*RADIX +: RADIX])
                );
            end
            if (l > 0) begin : g_tie
                // Tie off the vector bits above the cells of this level.
                assign up_v[l][N-1:USED] = '0;
                assign dn_v[l][N-1:USED] = '0;
            end
        end
        // Tie off the unused upper bits of the root level.
        assign up_v[LEVELS][N-1:1] = '0;
        assign dn_v[LEVELS][N-1:1] = '0;
    endgenerate
endmodule

// File: rtl/sel_multi.sv
// Cascaded select for several functional units.
// Stage s picks among the requests left over by stages 0..s-1, gated by
// unit_free[s]. Grants and valid flags are registered (one cycle latency).
module sel_multi #(
    parameter int unsigned N      = 64,
    parameter int unsigned STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N-1:0]               req,
    input  logic [STAGES-1:0]          unit_free,
    output logic [STAGES-1:0][N-1:0]   grant,
    output logic [STAGES-1:0]          grant_vld
);
    logic [N-1:0]              stage_req [STAGES];
    logic [STAGES-1:0][N-1:0]  gnt_c;
    logic [STAGES-1:0]         any_c;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign stage_req[s] = req;
            end else begin : g_next
                assign stage_req[s] = stage_req[s-1] & ~gnt_c[s-1];
            end
            sel_tree #(.N(N)) u_tree (
                .req_i     (stage_req[s]),
                .root_en_i (unit_free[s]),
                .gnt_o     (gnt_c[s]),
                .any_o     (any_c[s])
            );
        end
    endgenerate

    // Register the grants and valid flags for the issue stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant     <= '0;
            grant_vld <= '0;
        end else begin
            grant     <= gnt_c;
            grant_vld <= any_c & unit_free;
        end
    end
endmodule

// File: rtl/sel_multi_chk.sv
// Property checker for sel_multi, attached to it by bind.
module sel_multi_chk #(
    parameter int unsigned N      = 64,
    parameter int unsigned STAGES = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N-1:0]             req,
    input logic [STAGES-1:0]        unit_free,
    input logic [STAGES-1:0][N-1:0] grant,
    input logic [STAGES-1:0]        grant_vld
);
    // R1: a reset edge clears the outputs.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (grant == '0 && grant_vld == '0));

    // R7: the first two stages never grant the same entry.
    a_r7_no_double: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] & grant[1]) == '0);

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_s
            // R6: each grant vector is one-hot or zero.
            a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(grant[s]));
            // R6: the valid flag matches a nonzero grant.
            a_r6_vld_match: assert property (@(posedge clk) disable iff (!rst_n)
                grant_vld[s] == (grant[s] != '0));
            // R4: a busy unit receives no grant.
            a_r4_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
                !unit_free[s] |=> grant[s] == '0);
            // R8: grants go only to entries that were requesting.
            a_r8_subset: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (grant[s] & ~$past(req)) == '0);
        end
    endgenerate
endmodule

bind sel_multi sel_multi_chk #(.N(N), .STAGES(STAGES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .unit_free (unit_free),
    .grant     (grant),
    .grant_vld (grant_vld)
);

// File: tb/sel_multi_tb.sv
module sel_multi_tb;
    localparam int N = 64;
    localparam int S = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N-1:0]         req = '0;
    logic [S-1:0]         unit_free = '0;
    logic [S-1:0][N-1:0]  grant;
    logic [S-1:0]         grant_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    sel_multi #(.N(N), .STAGES(S)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .unit_free(unit_free),
        .grant(grant), .grant_vld(grant_vld)
    );

    always #2 clk = ~clk;

    // Returns the lowest set bit of v as a one-hot vector (zero if v is zero).
    function automatic logic [N-1:0] lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return (N'(1) << i);
        return '0;
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one pattern, let a rising edge pass, then compare both stages.
    task automatic apply(input logic [N-1:0] r, input logic [S-1:0] f);
        logic [N-1:0] left;
        logic [N-1:0] e;
        req = r;
        unit_free = f;
        @(negedge clk);
        left = r;
        for (int s = 0; s < S; s++) begin
            e = f[s] ? lowest(left) : '0;
            left = left & ~e;
            // R2, R3 (cascade masking), R4 (busy unit), R5 (none left)
            check(s == 0 ? "R2 stage0 grant" : "R3 stage1 grant", grant[s], e);
            // R6 valid flag
            check("R6 valid", N'(grant_vld[s]), N'(e != '0));
        end
        // R7 no overlap, R8 subset of requests
        check("R7 overlap", grant[0] & grant[1], '0);
        check("R8 subset", (grant[0] | grant[1]) & ~r, '0);
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        req = '1;
        unit_free = '1;
        @(negedge clk);
        @(negedge clk);
        // R1: requests present during reset yield no grants.
        check("R1 reset grant0", grant[0], '0);
        check("R1 reset grant1", grant[1], '0);
        check("R1 reset vld", N'(grant_vld), '0);
        rst_n = 1'b1;

        apply('0, 2'b11);                       // R5 empty window
        apply('1, 2'b11);                       // full window
        apply(N'(1) << 63, 2'b11);              // deepest path, R5 stage 1 empty
        apply(N'(1) << 5, 2'b11);               // single request
        apply((N'(1) << 17) | (N'(1) << 40), 2'b11); // different subtrees
        apply('1, 2'b00);                       // R4 both units busy
        apply('1, 2'b10);                       // R3 stage 0 busy
        apply((N'(1) << 9) | (N'(1) << 10), 2'b01);  // R4 stage 1 busy
        for (int n = 0; n < 300; n++) begin
            logic [N-1:0] r;
            r = {$urandom(), $urandom()};
            case (n % 3)
                0: r = r & {$urandom(), $urandom()} & {$urandom(), $urandom()};
                1: ;
                default: r = r | {$urandom(), $urandom()};
            endcase
            apply(r, S'($urandom_range(0, 3)));
        end
        // R1: a mid-run reset clears the outputs.
        rst_n = 1'b0;
        req = '1;
        @(negedge clk);
        check("R1 mid reset", grant[0] | grant[1], '0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule